// File: doc/BRIEF.md
# Compare-Toggle Timer with Prescaler and Postscaler

This block is a programmable timer/counter with two operating widths. In byte mode only the low count byte advances, and the high byte of the same register holds the compare period. When the low byte equals the period on an active count step, an event is produced and the low byte restarts from zero. In word mode both bytes advance together as one 16-bit count, and the event is the wrap from all-ones to zero.

A power-of-two prescaler divides the count-enable strobe before it reaches the counter. Events pass through a postscaler that lets every Nth event through. Each event that passes inverts the output and sets a sticky interrupt flag. Software reaches the block through a byte-wide register port. In word mode, reading the low byte also captures the high byte into a shadow, and the high byte written first is held until the low byte is written. This lets software read and load the full count as one value.

Register addresses: 0 is the low count byte. 1 is the high byte: the period in byte mode, or the buffered upper count in word mode. 2 is control: bit 0 run, bit 1 word mode, bits 7:4 postscale select. 3 holds bits 3:0 prescale select and bit 7 the interrupt flag; writing 1 to bit 7 clears the flag.

Top module: `cmp_toggle_timer`

## Requirements
- R1: After reset, out_o and irq_o are 0, the count is 0 and the control register (address 2) reads 0.
- R2: With prescale select S (address 3, bits 3:0), the counter takes one step every 2^S cycles in which clk_en_i is high and the run bit is set, for S from 0 to 15.
- R3: In byte mode, a step taken while the low byte equals the high byte produces an event and sets the low byte to 0. Other steps increment the low byte. The high byte never counts.
- R4: In word mode (control bit 1 = 1), each step increments the 16-bit count, and the step from 0xFFFF to 0x0000 produces an event.
- R5: With postscale select P (address 2, bits 7:4), only every (P+1)th event acts on the output.
- R6: out_o inverts on the same clock edge as each postscaled event, and irq_o is set on that edge.
- R7: irq_o stays set until a write to address 3 with bit 7 = 1. A write with bit 7 = 0 leaves it set. If a postscaled event happens in the same cycle as the clear, the flag stays set.
- R8: In word mode, a read of address 0 with rd_i high captures the high count byte. Later reads of address 1 return that captured value while the count keeps running.
- R9: In word mode, a write to address 1 only loads a holding byte and leaves the count unchanged. A write to address 0 then loads {held byte, written byte} into the count in one cycle.
- R10: A write to address 0, or a control write that changes the mode bit, clears the prescaler and postscaler progress.
- R11: When the run bit (address 2, bit 0) is 0 or clk_en_i is low, the count, out_o and irq_o do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Count enable strobe fed to the prescaler |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; with address 0 it captures the high byte |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| out_o | output | 1 | Toggled timer output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that clk_en_i, wr_i and rd_i are synchronous single-cycle-or-longer levels. They also assume that software writes to the count or the mode only while it is prepared to lose prescaler and postscaler progress. The checks on low-byte wrap ignore cycles in which a count write takes priority. The stimulus changes every input on the falling clock edge and stops the run bit before reprogramming. It reloads the count after each configuration change, so each test case starts with both dividers empty.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W     = 8;
  localparam int PSC_SEL_W  = 4;
  localparam int POST_SEL_W = 4;

  typedef enum logic [1:0] {
    A_CNT_LO = 2'd0,
    A_CNT_HI = 2'd1,
    A_CTRL   = 2'd2,
    A_PSC    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   ratio, lim;

  assign ratio  = (CNT_W+1)'(1) << sel_i;
  assign lim    = ratio - 1'b1;
  assign tick_o = step_i && ({1'b0, cnt_q} == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                mode16_i,
  input  logic                ld_lo_i,
  input  logic                ld_hi_i,
  input  logic [2*BYTE_W-1:0] ld_val_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                evt_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             match8;

  assign match8 = cnt_q[BYTE_W-1:0] == cnt_q[CNT_W-1:BYTE_W];
  assign evt_o  = tick_i && (mode16_i ? &cnt_q : match8);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (mode16_i)    cnt_d = cnt_q + 1'b1;
      else if (match8) cnt_d[BYTE_W-1:0] = '0;
      else             cnt_d[BYTE_W-1:0] = cnt_q[BYTE_W-1:0] + 1'b1;
    end
    if (ld_lo_i) cnt_d[BYTE_W-1:0]     = ld_val_i[BYTE_W-1:0];
    if (ld_hi_i) cnt_d[CNT_W-1:BYTE_W] = ld_val_i[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fire_o
);
  logic [SEL_W-1:0] cnt_q;

  assign fire_o = evt_i && (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (evt_i)  cnt_q <= fire_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cmp_toggle_timer.sv
module cmp_toggle_timer
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clk_en_i,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              out_o,
  output logic              irq_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic                  run_q, mode16_q, out_q, irq_q;
  logic [POST_SEL_W-1:0] post_sel_q;
  logic [PSC_SEL_W-1:0]  psc_sel_q;
  logic [BYTE_W-1:0]     rbuf_q, wbuf_q;
  logic [CNT_W-1:0]      cnt;
  logic wr_lo, wr_hi, wr_ctrl, wr_psc, mode_chg, cnt_wr, div_clr;
  logic ld_hi, irq_clr, step, tick, evt, fire;
  logic [CNT_W-1:0] ld_val;

  assign wr_lo    = wr_i && (addr_i == A_CNT_LO);
  assign wr_hi    = wr_i && (addr_i == A_CNT_HI);
  assign wr_ctrl  = wr_i && (addr_i == A_CTRL);
  assign wr_psc   = wr_i && (addr_i == A_PSC);
  assign mode_chg = wr_ctrl && (wdata_i[1] != mode16_q);
  assign cnt_wr   = wr_lo;
  assign div_clr  = cnt_wr || mode_chg;
  // word mode commits the held high byte together with the low byte
  assign ld_hi    = mode16_q ? wr_lo : wr_hi;
  assign ld_val   = mode16_q ? {wbuf_q, wdata_i} : {wdata_i, wdata_i};
  assign irq_clr  = wr_psc && wdata_i[BYTE_W-1];
  assign step     = clk_en_i && run_q;

  tmr_prescaler #(.SEL_W(PSC_SEL_W)) u_psc (
    .clk_i, .rst_ni, .clr_i(div_clr), .step_i(step), .sel_i(psc_sel_q), .tick_o(tick)
  );

  tmr_count #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .mode16_i(mode16_q), .ld_lo_i(wr_lo),
    .ld_hi_i(ld_hi), .ld_val_i(ld_val), .cnt_o(cnt), .evt_o(evt)
  );

  tmr_postscaler #(.SEL_W(POST_SEL_W)) u_post (
    .clk_i, .rst_ni, .clr_i(div_clr), .evt_i(evt), .sel_i(post_sel_q), .fire_o(fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      mode16_q   <= 1'b0;
      post_sel_q <= '0;
      psc_sel_q  <= '0;
      rbuf_q     <= '0;
      wbuf_q     <= '0;
      out_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q      <= wdata_i[0];
        mode16_q   <= wdata_i[1];
        post_sel_q <= wdata_i[BYTE_W-1 -: POST_SEL_W];
      end
      if (wr_psc)                  psc_sel_q <= wdata_i[PSC_SEL_W-1:0];
      if (wr_hi && mode16_q)       wbuf_q    <= wdata_i;
      if (rd_i && addr_i == A_CNT_LO) rbuf_q <= cnt[CNT_W-1:BYTE_W];
      if (fire)                    out_q     <= ~out_q;
      if (fire)                    irq_q     <= 1'b1;
      else if (irq_clr)            irq_q     <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CNT_LO: rdata_o = cnt[BYTE_W-1:0];
      A_CNT_HI: rdata_o = mode16_q ? rbuf_q : cnt[CNT_W-1:BYTE_W];
      A_CTRL:   rdata_o = {post_sel_q, {(BYTE_W-POST_SEL_W-2){1'b0}}, mode16_q, run_q};
      default:  rdata_o = {irq_q, {(BYTE_W-PSC_SEL_W-1){1'b0}}, psc_sel_q};
    endcase
  end

  assign out_o = out_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/cmp_toggle_timer_chk.sv
module cmp_toggle_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_en_i,
  input logic       run_i,
  input logic       mode16_i,
  input logic       tick_i,
  input logic       evt_i,
  input logic       fire_i,
  input logic       cnt_wr_i,
  input logic       irq_clr_i,
  input logic [7:0] cnt_lo_i,
  input logic       out_i,
  input logic       irq_i
);
  p_tick_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (clk_en_i && run_i));

  p_evt_needs_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |-> tick_i);

  p_lo_wraps_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !mode16_i && !cnt_wr_i) |=> (cnt_lo_i == 8'd0));

  p_fire_sets_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> irq_i);

  p_irq_with_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> !$stable(out_i));

  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !fire_i) |=> !irq_i);

  p_out_needs_run_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_i) |-> $past(clk_en_i && run_i));
endmodule

bind cmp_toggle_timer cmp_toggle_timer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_i  (clk_en_i),
  .run_i     (run_q),
  .mode16_i  (mode16_q),
  .tick_i    (tick),
  .evt_i     (evt),
  .fire_i    (fire),
  .cnt_wr_i  (cnt_wr),
  .irq_clr_i (irq_clr),
  .cnt_lo_i  (cnt[7:0]),
  .out_i     (out_o),
  .irq_i     (irq_o)
);

// File: tb/cmp_toggle_timer_bench.sv
module cmp_toggle_timer_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       out_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  cmp_toggle_timer u_cmp_toggle_timer (.*);

  typedef struct packed {
    logic        mode;
    logic [3:0]  ps;
    logic [3:0]  pos;
    logic [7:0]  hi;
    logic [7:0]  lo;
    int unsigned exp;
  } vec_t;

  // exp = clk_en cycles until first toggle: steps*(2^ps), steps = events_to_first*(pos+1)
  localparam vec_t VECS [10] = '{
    '{1'b0, 4'd0,  4'd0,  8'h00, 8'h00, 1},
    '{1'b0, 4'd0,  4'd0,  8'h05, 8'h00, 6},
    '{1'b0, 4'd1,  4'd0,  8'h03, 8'h00, 8},
    '{1'b0, 4'd0,  4'd2,  8'h02, 8'h00, 9},
    '{1'b0, 4'd3,  4'd1,  8'h01, 8'h00, 32},
    '{1'b0, 4'd0,  4'd15, 8'h00, 8'h00, 16},
    '{1'b0, 4'd0,  4'd0,  8'h09, 8'h07, 3},
    '{1'b1, 4'd0,  4'd0,  8'hFF, 8'hF0, 16},
    '{1'b1, 4'd2,  4'd0,  8'hFF, 8'hFE, 8},
    '{1'b0, 4'd15, 4'd0,  8'h00, 8'h00, 32768}
  };

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr_i = a; rd_i = 1'b1;
    #1 v = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic pulse(input int unsigned n);
    clk_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    clk_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic o0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(out_o == 1'b0, "R1 out", out_o, 0);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd0, v); chk(v == 8'h00, "R1 count", v, 0);

    // R11 run bit clear: no counting
    wr(2'd1, 8'h20);
    pulse(5);
    rd(2'd0, v); chk(v == 8'h00, "R11 stopped count", v, 0);
    chk(out_o == 1'b0, "R11 stopped out", out_o, 0);

    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < 10; i++) begin
      wr(2'd2, {VECS[i].pos, 2'b00, VECS[i].mode, 1'b0});
      wr(2'd3, {1'b1, 3'b000, VECS[i].ps});
      wr(2'd1, VECS[i].hi);
      wr(2'd0, VECS[i].lo);
      wr(2'd2, {VECS[i].pos, 2'b00, VECS[i].mode, 1'b1});
      o0 = out_o;
      pulse(VECS[i].exp - 1);
      chk(out_o == o0, "R2/R5 early toggle", out_o, o0);
      chk(irq_o == 1'b0, "R6 early irq", irq_o, 0);
      pulse(1);
      chk(out_o == !o0, "R3/R4/R5 toggle", out_o, !o0);
      chk(irq_o == 1'b1, "R6 irq set", irq_o, 1);
    end

    // R7 sticky flag
    wr(2'd3, 8'h00);
    chk(irq_o == 1'b1, "R7 write 0 keeps flag", irq_o, 1);
    wr(2'd3, 8'h80);
    chk(irq_o == 1'b0, "R7 write 1 clears", irq_o, 0);

    // R11 clk_en low while running
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h03);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    repeat (6) @(negedge clk_i);
    rd(2'd0, v); chk(v == 8'h00, "R11 clk_en low", v, 0);

    // R3 low byte wrap, high byte holds period
    pulse(3);
    rd(2'd0, v); chk(v == 8'h03, "R3 at period", v, 3);
    pulse(1);
    rd(2'd0, v); chk(v == 8'h00, "R3 wrap to zero", v, 0);
    rd(2'd1, v); chk(v == 8'h03, "R3 high byte held", v, 3);

    // R10 count write clears prescaler progress
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h82);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h01);
    o0 = out_o;
    pulse(3);
    wr(2'd0, 8'h00);
    pulse(3);
    chk(out_o == o0, "R10 prescaler cleared", out_o, o0);
    pulse(1);
    chk(out_o == !o0, "R10 toggle after full ratio", out_o, !o0);

    // R10 count write clears postscaler progress
    wr(2'd3, 8'h80);
    wr(2'd2, 8'h11);
    wr(2'd0, 8'h00);
    o0 = out_o;
    pulse(1);
    wr(2'd0, 8'h00);
    pulse(1);
    chk(out_o == o0, "R10 postscaler cleared", out_o, o0);
    pulse(1);
    chk(out_o == !o0, "R10 post toggle", out_o, !o0);

    // R8 buffered read in word mode
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h80);
    wr(2'd1, 8'h12);
    wr(2'd0, 8'hFF);
    wr(2'd2, 8'h03);
    pulse(1);
    rd(2'd0, v); chk(v == 8'h00, "R8 low byte", v, 0);
    pulse(256);
    rd(2'd1, v); chk(v == 8'h13, "R8 captured high", v, 8'h13);
    rd(2'd0, v);
    rd(2'd1, v); chk(v == 8'h14, "R8 new capture", v, 8'h14);

    // R9 buffered write in word mode
    wr(2'd1, 8'hAB);
    rd(2'd0, v); chk(v == 8'h00, "R9 low unchanged", v, 0);
    rd(2'd1, v); chk(v == 8'h14, "R9 high unchanged", v, 8'h14);
    wr(2'd0, 8'hCD);
    rd(2'd0, v); chk(v == 8'hCD, "R9 low loaded", v, 8'hCD);
    rd(2'd1, v); chk(v == 8'hAB, "R9 high loaded", v, 8'hAB);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule